// File: doc/BRIEF.md
# Sync-Hunting Frame Receiver with CRC Check

This block sits behind a byte-wide serial receiver on the host side of a point-to-point link. Each received byte arrives with a one-cycle valid strobe. The parser discards bytes until it sees the sync value 0xAA. It then reads a 16-bit length, sent most significant byte first, and forwards that many payload bytes one at a time. A 16-bit checksum trailer follows the payload. At the end of every frame the parser reports whether the checksum matched.

A length above the legal maximum is treated as a false lock. In that case the parser flags an error and starts hunting again. A synchronous abort, for example driven by the link's select line going inactive, returns the parser to hunting from any state. Three saturating counters record good frames, corrupt frames and bytes skipped while hunting.

States: `ST_HUNT` (searching for the sync value), `ST_LEN_HI` and `ST_LEN_LO` (length bytes), `ST_PAYLOAD` (forwarding bytes), `ST_CRC_HI` and `ST_CRC_LO` (trailer). Transitions:
- hunt→len_hi when the sync value arrives.
- len_hi→len_lo on any byte.
- len_lo→payload when the length is between 1 and the maximum.
- len_lo→crc_hi when the length is zero.
- len_lo→hunt when the length is too large.
- payload→crc_hi on the last payload byte.
- crc_hi→crc_lo on any byte.
- crc_lo→hunt on any byte.
- any state→hunt on abort.

Top module: `sync_frame_rx`

## Requirements
- R1: After reset the state is `ST_HUNT`. All strobes (`pay_valid_o`, `done_o`, `crc_ok_o`, `len_err_o`) are 0 and all three counters read 0.
- R2: In `ST_HUNT`, every accepted byte other than 0xAA is dropped. It produces no payload strobe, and `skip_cnt_o` rises by one in the cycle after that byte.
- R3: The two bytes after 0xAA form the length L, high byte first. The next L accepted bytes each appear on `pay_byte_o`, with `pay_valid_o` high, in the cycle after they are accepted. This holds even for bytes equal to 0xAA. Sync, length and trailer bytes never raise `pay_valid_o`.
- R4: The checksum uses polynomial 0x1021 with initial value 0xFFFF, no bit reflection and no final inversion. It covers the payload bytes only. The trailer is sent high byte first. When the trailer matches, `done_o` and `crc_ok_o` are both 1 for one cycle, the cycle after the last trailer byte, and `good_cnt_o` rises by one.
- R5: When the trailer does not match, `done_o` is 1 with `crc_ok_o` 0 and `bad_cnt_o` rises by one. `good_cnt_o` does not change.
- R6: A length of 295 is accepted. A length of 296 or more pulses `len_err_o` for one cycle after the low length byte and returns to `ST_HUNT` without raising `done_o`.
- R7: A length of 0 goes straight to the trailer. The expected checksum is then 0xFFFF.
- R8: When `abort_i` is high, the parser enters `ST_HUNT` at the next edge. The byte offered in that cycle is ignored, no strobe is raised and no counter moves.
- R9: Cycles with `in_valid_i` low change neither state nor outputs. Gaps may appear anywhere inside a frame.
- R10: Each counter saturates at 65535 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_i | input | 1 | Return to hunting; the byte in this cycle is dropped |
| in_valid_i | input | 1 | A byte is offered this cycle |
| in_byte_i | input | 8 | Received byte |
| pay_valid_o | output | 1 | Payload byte present on `pay_byte_o` |
| pay_byte_o | output | 8 | Forwarded payload byte |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| crc_ok_o | output | 1 | Trailer matched (valid with `done_o`) |
| len_err_o | output | 1 | One-cycle pulse on an illegal length |
| good_cnt_o | output | 16 | Frames with a matching trailer |
| bad_cnt_o | output | 16 | Frames with a mismatching trailer |
| skip_cnt_o | output | 16 | Bytes discarded while hunting |

## Verification
The assertions assume that reset is held for at least two clock edges. This gives every `$past` term a defined value from reset. They also rely on the framing itself: every frame has at least five bytes, so two `done_o` pulses can never be adjacent. The bench respects both assumptions. It holds reset for several cycles and builds every frame through one task that always sends sync, two length bytes and two trailer bytes. It drives inputs and samples outputs two nanoseconds after each rising edge, so every byte's effect is read in the cycle the requirements name.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 16;
    localparam int CRC_W  = 16;
    localparam int NUM_CNT  = 3;
    localparam int CNT_GOOD = 0;
    localparam int CNT_BAD  = 1;
    localparam int CNT_SKIP = 2;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_PAYLOAD,
        ST_CRC_HI,
        ST_CRC_LO
    } rx_state_e;
endpackage

// File: rtl/sfr_crc16.sv
module sfr_crc16 #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  POLY = 16'h1021,
    parameter logic [W-1:0]  INIT = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         en_i,
    input  logic [7:0]   data_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_q;
    logic [W-1:0] crc_nx;

    // Serial form: one input bit enters the feedback per step, MSB first.
    always_comb begin
        crc_nx = crc_q;
        for (int i = 7; i >= 0; i--) begin
            if (crc_nx[W-1] ^ data_i[i])
                crc_nx = {crc_nx[W-2:0], 1'b0} ^ POLY;
            else
                crc_nx = {crc_nx[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= INIT;
        else if (init_i) crc_q <= INIT;
        else if (en_i)   crc_q <= crc_nx;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/sfr_sat_cnt.sv
module sfr_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc_i && (cnt_q != {W{1'b1}}))
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sync_frame_rx.sv
module sync_frame_rx
    import sfr_pkg::*;
#(
    parameter int          MAX_PAYLOAD = 295,
    parameter int          CNT_W       = 16,
    parameter logic [7:0]  SYNC_BYTE   = 8'hAA,
    parameter logic [15:0] CRC_POLY    = 16'h1021,
    parameter logic [15:0] CRC_INIT    = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort_i,
    input  logic             in_valid_i,
    input  logic [7:0]       in_byte_i,
    output logic             pay_valid_o,
    output logic [7:0]       pay_byte_o,
    output logic             done_o,
    output logic             crc_ok_o,
    output logic             len_err_o,
    output logic [CNT_W-1:0] good_cnt_o,
    output logic [CNT_W-1:0] bad_cnt_o,
    output logic [CNT_W-1:0] skip_cnt_o
);
    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_PAYLOAD);

    rx_state_e          state_q, state_nx;
    logic [7:0]         len_hi_q;
    logic [LEN_W-1:0]   remain_q;
    logic [7:0]         trl_hi_q;
    logic [CRC_W-1:0]   crc_cur;

    logic               take;
    logic [LEN_W-1:0]   len_w;
    logic               ev_skip, ev_sync, ev_pay, ev_lenerr, ev_end, crc_match;

    assign take      = in_valid_i && !abort_i;
    assign len_w     = {len_hi_q, in_byte_i};
    assign crc_match = ({trl_hi_q, in_byte_i} == crc_cur);

    // Byte events derived from the current state
    always_comb begin
        ev_skip   = 1'b0;
        ev_sync   = 1'b0;
        ev_pay    = 1'b0;
        ev_lenerr = 1'b0;
        ev_end    = 1'b0;
        if (take) begin
            unique case (state_q)
                ST_HUNT: begin
                    ev_sync = (in_byte_i == SYNC_BYTE);
                    ev_skip = (in_byte_i != SYNC_BYTE);
                end
                ST_LEN_LO:  ev_lenerr = (len_w > LEN_LIMIT);
                ST_PAYLOAD: ev_pay    = 1'b1;
                ST_CRC_LO:  ev_end    = 1'b1;
                default: ;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        if (abort_i) begin
            state_nx = ST_HUNT;
        end else if (in_valid_i) begin
            unique case (state_q)
                ST_HUNT:    if (in_byte_i == SYNC_BYTE) state_nx = ST_LEN_HI;
                ST_LEN_HI:  state_nx = ST_LEN_LO;
                ST_LEN_LO: begin
                    if (len_w > LEN_LIMIT)   state_nx = ST_HUNT;
                    else if (len_w == '0)    state_nx = ST_CRC_HI;
                    else                     state_nx = ST_PAYLOAD;
                end
                ST_PAYLOAD: if (remain_q == LEN_W'(1)) state_nx = ST_CRC_HI;
                ST_CRC_HI:  state_nx = ST_CRC_LO;
                ST_CRC_LO:  state_nx = ST_HUNT;
                default:    state_nx = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_nx;
    end

    // Frame bookkeeping: length high byte, remaining count, trailer high byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_hi_q <= '0;
            remain_q <= '0;
            trl_hi_q <= '0;
        end else if (take) begin
            if (state_q == ST_LEN_HI)  len_hi_q <= in_byte_i;
            if (state_q == ST_LEN_LO)  remain_q <= len_w;
            if (state_q == ST_PAYLOAD) remain_q <= remain_q - 1'b1;
            if (state_q == ST_CRC_HI)  trl_hi_q <= in_byte_i;
        end
    end

    sfr_crc16 #(
        .W    (CRC_W),
        .POLY (CRC_POLY),
        .INIT (CRC_INIT)
    ) crc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (ev_sync),
        .en_i   (ev_pay),
        .data_i (in_byte_i),
        .crc_o  (crc_cur)
    );

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_valid_o <= 1'b0;
            pay_byte_o  <= '0;
            done_o      <= 1'b0;
            crc_ok_o    <= 1'b0;
            len_err_o   <= 1'b0;
        end else begin
            pay_valid_o <= ev_pay;
            if (ev_pay) pay_byte_o <= in_byte_i;
            done_o      <= ev_end;
            crc_ok_o    <= ev_end && crc_match;
            len_err_o   <= ev_lenerr;
        end
    end

    // Statistics counters
    logic [NUM_CNT-1:0]            inc_v;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_v;

    always_comb begin
        inc_v           = '0;
        inc_v[CNT_GOOD] = ev_end && crc_match;
        inc_v[CNT_BAD]  = ev_end && !crc_match;
        inc_v[CNT_SKIP] = ev_skip;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        sfr_sat_cnt #(.W(CNT_W)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (inc_v[g]),
            .cnt_o (cnt_v[g])
        );
    end

    assign good_cnt_o = cnt_v[CNT_GOOD];
    assign bad_cnt_o  = cnt_v[CNT_BAD];
    assign skip_cnt_o = cnt_v[CNT_SKIP];
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             abort_i,
    input logic             in_valid_i,
    input logic             pay_valid_o,
    input logic             done_o,
    input logic             crc_ok_o,
    input logic             len_err_o,
    input logic [CNT_W-1:0] good_cnt_o,
    input logic [CNT_W-1:0] bad_cnt_o,
    input logic [CNT_W-1:0] skip_cnt_o
);
    p_pay_needs_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid_o |-> $past(in_valid_i));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_ok_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok_o |-> done_o);

    p_lenerr_not_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && len_err_o));

    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(abort_i) |-> (!pay_valid_o && !done_o && !len_err_o));

    p_skip_needs_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_cnt_o != $past(skip_cnt_o)) |-> $past(in_valid_i && !abort_i));

    p_good_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (good_cnt_o != $past(good_cnt_o)) |-> (good_cnt_o == $past(good_cnt_o) + 1'b1));

    p_bad_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_cnt_o != $past(bad_cnt_o)) |-> (bad_cnt_o == $past(bad_cnt_o) + 1'b1));

    p_skip_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_cnt_o != $past(skip_cnt_o)) |-> (skip_cnt_o == $past(skip_cnt_o) + 1'b1));
endmodule

bind sync_frame_rx sfr_checker #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort_i     (abort_i),
    .in_valid_i  (in_valid_i),
    .pay_valid_o (pay_valid_o),
    .done_o      (done_o),
    .crc_ok_o    (crc_ok_o),
    .len_err_o   (len_err_o),
    .good_cnt_o  (good_cnt_o),
    .bad_cnt_o   (bad_cnt_o),
    .skip_cnt_o  (skip_cnt_o)
);

// File: tb/sync_frame_rx_tb_top.sv
`timescale 1ns/1ps
module sync_frame_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_byte_i = 8'h00;
    logic        pay_valid_o, done_o, crc_ok_o, len_err_o;
    logic [7:0]  pay_byte_o;
    logic [15:0] good_cnt_o, bad_cnt_o, skip_cnt_o;

    always #10 clk = ~clk;

    sync_frame_rx dut_i (
        .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
        .in_valid_i(in_valid_i), .in_byte_i(in_byte_i),
        .pay_valid_o(pay_valid_o), .pay_byte_o(pay_byte_o),
        .done_o(done_o), .crc_ok_o(crc_ok_o), .len_err_o(len_err_o),
        .good_cnt_o(good_cnt_o), .bad_cnt_o(bad_cnt_o), .skip_cnt_o(skip_cnt_o)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int exp_good = 0, exp_bad = 0, exp_skip = 0;
    logic [7:0] pl [0:299];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {pl[i], 8'h00};
            for (int k = 0; k < 8; k++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    // Drive a byte, let one edge take it, then sample 2 ns after that edge.
    task automatic push(input logic [7:0] b);
        in_valid_i = 1'b1; in_byte_i = b; abort_i = 1'b0;
        @(posedge clk); #2;
        in_valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid_i = 1'b0; abort_i = 1'b0;
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic chk_counters(input string req);
        chk(good_cnt_o == exp_good[15:0], {req, " good count"}, good_cnt_o, exp_good);
        chk(bad_cnt_o  == exp_bad[15:0],  {req, " bad count"},  bad_cnt_o,  exp_bad);
        chk(skip_cnt_o == exp_skip[15:0], {req, " skip count"}, skip_cnt_o, exp_skip);
    endtask

    task automatic chk_quiet(input string req);
        chk(!pay_valid_o && !done_o && !len_err_o, {req, " no strobe"},
            {pay_valid_o, done_o, len_err_o}, 0);
    endtask

    // Send one frame from pl[0:n-1]; optionally spoil the trailer or insert gaps.
    task automatic send_frame(input int n, input bit spoil, input bit gaps, input string req);
        logic [15:0] c;
        c = ref_crc(n);
        if (spoil) c ^= 16'h0100;
        push(8'hAA);            chk_quiet({req, " R3 sync"});
        if (gaps) begin idle(2); chk_quiet("R9 gap after sync"); end
        push(8'(n >> 8));       chk_quiet({req, " R3 len hi"});
        push(8'(n));            chk_quiet({req, " R3 len lo"});
        for (int i = 0; i < n; i++) begin
            push(pl[i]);
            chk(pay_valid_o && pay_byte_o == pl[i], {req, " R3 payload byte"},
                {pay_valid_o, pay_byte_o}, {1'b1, pl[i]});
            if (gaps && i == 0) begin idle(3); chk_quiet("R9 gap in payload"); end
        end
        push(c[15:8]);          chk_quiet({req, " R3 crc hi"});
        push(c[7:0]);
        chk(done_o && (crc_ok_o == !spoil), {req, spoil ? " R5 done/bad" : " R4 done/ok"},
            {done_o, crc_ok_o}, {1'b1, !spoil});
        if (spoil) exp_bad++; else exp_good++;
        chk_counters(req);
        idle(1);
        chk(!done_o && !crc_ok_o, {req, " R4 single-cycle done"}, {done_o, crc_ok_o}, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle(4);
        chk(!pay_valid_o && !done_o && !crc_ok_o && !len_err_o, "R1 strobes at reset",
            {pay_valid_o, done_o, crc_ok_o, len_err_o}, 0);
        rst_n = 1'b1; idle(1);
        chk_counters("R1");
    endtask

    task automatic t_hunt();
        logic [7:0] junk [5] = '{8'h00, 8'h55, 8'hAB, 8'hFF, 8'h2A};
        for (int i = 0; i < 5; i++) begin
            push(junk[i]); exp_skip++;
            chk_quiet("R2 hunting byte");
            chk(skip_cnt_o == exp_skip[15:0], "R2 skip increment", skip_cnt_o, exp_skip);
        end
    endtask

    task automatic t_known_vector();
        string s = "123456789";
        for (int i = 0; i < 9; i++) pl[i] = s[i];
        chk(ref_crc(9) == 16'h29B1, "R4 bench reference value", ref_crc(9), 16'h29B1);
        send_frame(9, 1'b0, 1'b0, "R4 known vector");
    endtask

    task automatic t_patterns();
        pl[0] = 8'h42; send_frame(1, 1'b0, 1'b0, "R3 one byte");
        for (int i = 0; i < 7; i++) pl[i] = (i % 2) ? 8'hAA : 8'(i * 37);
        send_frame(7, 1'b0, 1'b0, "R3 sync inside payload");
        for (int i = 0; i < 40; i++) pl[i] = 8'(i * 13 + 5);
        send_frame(40, 1'b0, 1'b0, "R4 forty bytes");
    endtask

    task automatic t_corrupt();
        for (int i = 0; i < 12; i++) pl[i] = 8'(255 - i);
        send_frame(12, 1'b1, 1'b0, "R5 spoiled trailer");
        send_frame(12, 1'b0, 1'b0, "R5 recovery frame");
    endtask

    task automatic t_zero_len();
        chk(ref_crc(0) == 16'hFFFF, "R7 empty checksum", ref_crc(0), 16'hFFFF);
        send_frame(0, 1'b0, 1'b0, "R7 zero length");
    endtask

    task automatic t_lengths();
        for (int i = 0; i < 295; i++) pl[i] = 8'(i ^ 8'h5A);
        send_frame(295, 1'b0, 1'b0, "R6 max length");
        push(8'hAA); push(8'h01); push(8'h28);
        chk(len_err_o && !done_o && !pay_valid_o, "R6 len 296 error",
            {len_err_o, done_o, pay_valid_o}, 3'b100);
        push(8'h00); exp_skip++;
        chk(!len_err_o, "R6 error single cycle", len_err_o, 0);
        chk(skip_cnt_o == exp_skip[15:0], "R6 back to hunting", skip_cnt_o, exp_skip);
        chk_counters("R6");
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 5; i++) pl[i] = 8'(i + 1);
        send_frame(5, 1'b0, 1'b1, "R9 gapped frame");
    endtask

    task automatic t_abort();
        push(8'hAA); push(8'h00); push(8'h08);
        push(8'h11); push(8'h22);
        in_valid_i = 1'b1; in_byte_i = 8'hAA; abort_i = 1'b1;
        @(posedge clk); #2;
        in_valid_i = 1'b0; abort_i = 1'b0;
        chk_quiet("R8 abort cycle");
        chk_counters("R8 after abort");
        push(8'h01); exp_skip++;
        chk(skip_cnt_o == exp_skip[15:0], "R8 abort byte ignored, hunting", skip_cnt_o, exp_skip);
        for (int i = 0; i < 3; i++) pl[i] = 8'(8'hC0 + i);
        send_frame(3, 1'b0, 1'b0, "R8 frame after abort");
    endtask

    task automatic t_saturate();
        in_valid_i = 1'b1; in_byte_i = 8'h55;
        repeat (65540) @(posedge clk);
        #2; in_valid_i = 1'b0;
        exp_skip = 65535;
        chk(skip_cnt_o == 16'hFFFF, "R10 skip saturates", skip_cnt_o, 16'hFFFF);
        push(8'h33);
        chk(skip_cnt_o == 16'hFFFF, "R10 stays saturated", skip_cnt_o, 16'hFFFF);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2;
        t_reset();
        t_hunt();
        t_known_vector();
        t_patterns();
        t_corrupt();
        t_zero_len();
        t_lengths();
        t_gaps();
        t_abort();
        t_saturate();
        report();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        report();
    end
endmodule